// File: doc/BRIEF.md
# Diagnostic LED Blink-Code Annunciator

This block drives one status LED through an active-low pin and uses it to show four operator-visible conditions. After a normal reset the LED is dark. A self-test start strobe turns it on solid. A failure strobe starts one of two blink patterns. A numbered failure appears as repeating bursts of N short flashes with a long dark gap after each burst, so an operator can count N. A memory failure appears as an even, ungrouped on/off blink with no gaps, so it cannot be mistaken for any numbered code.

All pattern timing comes from an internal tick prescaler: one tick is `TICK_DIV` clock cycles. A flash lasts one tick on and one tick off, and the dark gap between bursts lasts `GAP_TICKS` ticks. Once a blink pattern is running it is latched. Only the synchronous reset leaves it. A 2-bit debug output reports the current mode so the pin waveform can be cross-checked.

Top module: `ledBlinkAnnunciator`

## Requirements
- R1: `ledPinN` is the inverse of the internal LED-on bit: it is 0 while the LED is lit and 1 while it is dark.
- R2: While `rst` is 1 at a clock edge, the mode returns to dark (`modeDbg` = 2'b00, `ledPinN` = 1). The mode then stays dark until a self-test start or a failure strobe is accepted.
- R3: When `selfTestStart` is 1 in dark or solid mode, and `failStrobe` is 0, the mode becomes solid (`modeDbg` = 2'b01) at the next edge. The LED then stays lit with no blinking.
- R4: A failure with `failRam` = 0 and `failCode[3:0]` in 2..8 enters coded mode (`modeDbg` = 2'b10). Each burst has exactly `failCode` flashes, and each flash is 1 tick on followed by 1 tick off.
- R5: In coded mode the last flash of a burst is followed by `GAP_TICKS` dark ticks instead of 1. The burst-and-gap cycle repeats without end.
- R6: A failure with `failRam` = 1 enters memory-fail mode (`modeDbg` = 2'b11), whatever `failCode` holds. The LED then alternates 1 tick on and 1 tick off, with no longer dark run.
- R7: A `failCode` of 0, 1 or 9..15 is shown as 8 flashes per burst.
- R8: When a failure is accepted, the tick prescaler restarts. The LED is dark for exactly one tick, and the first flash (or first on phase) begins at the following tick boundary.
- R9: In coded or memory-fail mode, `selfTestStart` and `failStrobe` are ignored. The mode and the pin waveform continue unchanged, and only `rst` leaves the mode.
- R10: A failure strobe is accepted from both dark and solid mode. When `selfTestStart` and `failStrobe` are 1 in the same cycle, the failure wins.
- R11: `modeDbg` encodes the mode as 00 dark, 01 solid, 10 coded, 11 memory-fail.
- R12: In the blink modes the LED changes only at tick boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; returns the LED to dark |
| selfTestStart | input | 1 | One-cycle strobe: self-test has begun |
| failStrobe | input | 1 | One-cycle strobe: a test failed |
| failCode | input | CODE_W (4) | Failure number sampled with `failStrobe` |
| failRam | input | 1 | Sampled with `failStrobe`; 1 selects the memory-fail pattern |
| ledPinN | output | 1 | Active-low LED drive |
| modeDbg | output | 2 | Current mode encoding |

## Verification
The bench builds the block with `TICK_DIV` = 3 and `GAP_TICKS` = 4. This keeps the longest burst period (8 flashes, 19 ticks) to 57 cycles, so two full periods of every code, including the clamped values, fit into short per-vector windows. With three cycles per tick, the bench can also see that the LED holds steady between tick boundaries and that the single dark tick after entry lasts exactly three cycles. It compares the pin cycle by cycle with a waveform model computed from the tick counts. It also counts the flashes in each burst and measures the longest dark run.

// File: rtl/ledAnnPkg.sv
package ledAnnPkg;

  localparam int FLASH_W = 4;

  typedef enum logic [1:0] {
    MODE_DARK  = 2'd0,
    MODE_SOLID = 2'd1,
    MODE_CODED = 2'd2,
    MODE_RAM   = 2'd3
  } annMode_e;

  // Strobes handed from control to the pattern datapath
  typedef struct packed {
    logic               enterBlink;
    logic [FLASH_W-1:0] flashCount;
  } blinkCmd_t;

endpackage

// File: rtl/ledAnnTicker.sv
module ledAnnTicker #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst || restart)      divCnt <= '0;
    else if (divCnt == LAST) divCnt <= '0;
    else                     divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == LAST);

  // R12: tick pulses come from a counter that never leaves its range
  assert_tick_bounded_R12: assert property (@(posedge clk) disable iff (rst)
    divCnt <= LAST);

endmodule

// File: rtl/ledAnnCtrl.sv
module ledAnnCtrl
  import ledAnnPkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int MIN_FLASH = 2,
  parameter int MAX_FLASH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selfTestStart,
  input  logic              failStrobe,
  input  logic [CODE_W-1:0] failCode,
  input  logic              failRam,
  output annMode_e          mode,
  output blinkCmd_t         cmd
);
  localparam logic [CODE_W-1:0] MIN_C = CODE_W'(MIN_FLASH);
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_FLASH);

  logic blinking, acceptFail, acceptStart;
  logic [FLASH_W-1:0] clampedCount;

  assign blinking    = (mode == MODE_CODED) || (mode == MODE_RAM);
  assign acceptFail  = failStrobe && !blinking;
  assign acceptStart = selfTestStart && !failStrobe && !blinking;

  always_comb begin
    if (failCode < MIN_C || failCode > MAX_C) clampedCount = FLASH_W'(MAX_FLASH);
    else                                      clampedCount = FLASH_W'(failCode);
  end

  always_comb begin
    cmd.enterBlink = acceptFail;
    cmd.flashCount = clampedCount;
  end

  always_ff @(posedge clk) begin
    if (rst)              mode <= MODE_DARK;
    else if (acceptFail)  mode <= failRam ? MODE_RAM : MODE_CODED;
    else if (acceptStart) mode <= MODE_SOLID;
  end

  // R2: dark holds without a strobe
  assert_dark_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DARK && !selfTestStart && !failStrobe) |=> mode == MODE_DARK);

  // R3: start strobe leads to solid
  assert_start_solid_R3: assert property (@(posedge clk) disable iff (rst)
    (selfTestStart && !failStrobe && !blinking) |=> mode == MODE_SOLID);

  // R10: failure accepted from dark or solid, winning over start
  assert_fail_enter_R10: assert property (@(posedge clk) disable iff (rst)
    (failStrobe && !blinking) |=> (mode == MODE_CODED || mode == MODE_RAM));

  // R9: blink modes are sticky until reset
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    blinking |=> mode == $past(mode));

endmodule

// File: rtl/ledAnnPattern.sv
module ledAnnPattern
  import ledAnnPkg::*;
#(
  parameter int TICK_DIV  = 1000,
  parameter int GAP_TICKS = 4,
  parameter int MAX_FLASH = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  annMode_e  mode,
  input  blinkCmd_t cmd,
  output logic      ledBit
);
  localparam int MAX_PERIOD = 2 * MAX_FLASH - 1 + GAP_TICKS;
  localparam int STEP_W     = $clog2(MAX_PERIOD + 1);

  logic               tick, armed, blinking;
  logic [STEP_W-1:0]  stepCnt, onSteps, period;
  logic [FLASH_W-1:0] burstLen;

  ledAnnTicker #(.TICK_DIV(TICK_DIV)) ticker (
    .clk     (clk),
    .rst     (rst),
    .restart (cmd.enterBlink),
    .tick    (tick)
  );

  assign blinking = (mode == MODE_CODED) || (mode == MODE_RAM);
  assign onSteps  = (STEP_W'(burstLen) << 1) - STEP_W'(1);
  assign period   = (mode == MODE_RAM) ? STEP_W'(2) : onSteps + STEP_W'(GAP_TICKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      stepCnt  <= '0;
      burstLen <= '0;
    end else if (cmd.enterBlink) begin
      armed    <= 1'b0;
      stepCnt  <= '0;
      burstLen <= cmd.flashCount;
    end else if (blinking && tick) begin
      if (!armed)                       armed   <= 1'b1;
      else if (stepCnt == period - 1'b1) stepCnt <= '0;
      else                               stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_DARK:  ledBit = 1'b0;
      MODE_SOLID: ledBit = 1'b1;
      MODE_CODED: ledBit = armed && (stepCnt < onSteps) && !stepCnt[0];
      MODE_RAM:   ledBit = armed && (stepCnt == '0);
      default:    ledBit = 1'b0;
    endcase
  end

  // R5: step index stays inside one burst-and-gap period
  assert_step_range_R5: assert property (@(posedge clk) disable iff (rst)
    (blinking && armed) |-> stepCnt < period);

  // R6: memory-fail pattern flips at every tick
  assert_ram_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RAM && armed && tick) |=> ledBit != $past(ledBit));

  // R8: dark right after a failure is taken
  assert_entry_dark_R8: assert property (@(posedge clk) disable iff (rst)
    cmd.enterBlink |=> !ledBit);

  // R8: first tick after entry lights the LED
  assert_first_flash_R8: assert property (@(posedge clk) disable iff (rst)
    (blinking && !armed && tick && !cmd.enterBlink) |=> ledBit);

  // R12: no change between ticks
  assert_tick_only_R12: assert property (@(posedge clk) disable iff (rst)
    (blinking && !tick && !cmd.enterBlink) |=> $stable(ledBit));

endmodule

// File: rtl/ledBlinkAnnunciator.sv
module ledBlinkAnnunciator
  import ledAnnPkg::*;
#(
  parameter int TICK_DIV  = 1000,
  parameter int GAP_TICKS = 4,
  parameter int CODE_W    = 4,
  parameter int MIN_FLASH = 2,
  parameter int MAX_FLASH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selfTestStart,
  input  logic              failStrobe,
  input  logic [CODE_W-1:0] failCode,
  input  logic              failRam,
  output logic              ledPinN,
  output logic [1:0]        modeDbg
);
  annMode_e  mode;
  blinkCmd_t cmd;
  logic      ledBit;

  ledAnnCtrl #(
    .CODE_W(CODE_W), .MIN_FLASH(MIN_FLASH), .MAX_FLASH(MAX_FLASH)
  ) ctrl (
    .clk(clk), .rst(rst), .selfTestStart(selfTestStart),
    .failStrobe(failStrobe), .failCode(failCode), .failRam(failRam),
    .mode(mode), .cmd(cmd)
  );

  ledAnnPattern #(
    .TICK_DIV(TICK_DIV), .GAP_TICKS(GAP_TICKS), .MAX_FLASH(MAX_FLASH)
  ) pattern (
    .clk(clk), .rst(rst), .mode(mode), .cmd(cmd), .ledBit(ledBit)
  );

  assign ledPinN = ~ledBit;
  assign modeDbg = mode;

  // R2: reset leaves the pin released and the mode dark
  assert_reset_dark_R2: assert property (@(posedge clk)
    $past(rst) |-> (ledPinN && modeDbg == 2'd0));

  // R1: solid mode pulls the pin low, dark mode releases it
  assert_pin_inverted_R1: assert property (@(posedge clk) disable iff (rst)
    (modeDbg == 2'd1 |-> !ledPinN) and (modeDbg == 2'd0 |-> ledPinN));

endmodule

// File: tb/ledBlinkAnnunciator_test.sv
`timescale 1ns/1ps
module ledBlinkAnnunciator_test;
  localparam int DIV = 3;
  localparam int GAP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic selfTestStart = 1'b0, failStrobe = 1'b0, failRam = 1'b0;
  logic [3:0] failCode = 4'd0;
  logic ledPinN;
  logic [1:0] modeDbg;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ledBlinkAnnunciator #(.TICK_DIV(DIV), .GAP_TICKS(GAP)) uut (
    .clk(clk), .rst(rst), .selfTestStart(selfTestStart), .failStrobe(failStrobe),
    .failCode(failCode), .failRam(failRam), .ledPinN(ledPinN), .modeDbg(modeDbg)
  );

  typedef struct packed {
    logic [3:0] code;
    logic       ram;
    logic       pre;
    logic [3:0] expN;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd2,  1'b0, 1'b1, 4'd2},
    '{4'd3,  1'b0, 1'b1, 4'd3},
    '{4'd5,  1'b0, 1'b0, 4'd5},
    '{4'd7,  1'b0, 1'b1, 4'd7},
    '{4'd8,  1'b0, 1'b1, 4'd8},
    '{4'd0,  1'b0, 1'b1, 4'd8},
    '{4'd1,  1'b0, 1'b0, 4'd8},
    '{4'd9,  1'b0, 1'b1, 4'd8},
    '{4'd4,  1'b1, 1'b1, 4'd0},
    '{4'd15, 1'b1, 1'b0, 4'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit expOn(input int n, input bit ram, input int c);
    int t, p;
    if (c < DIV) return 1'b0;
    t = (c - DIV) / DIV;
    if (ram) return (t % 2) == 0;
    p = 2 * n - 1 + GAP;
    return ((t % p) < 2 * n - 1) && ((t % p) % 2 == 0);
  endfunction

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); selfTestStart = 1'b1;
    @(negedge clk); selfTestStart = 1'b0;
  endtask

  task automatic pulseFail(input logic [3:0] code, input bit ram, input bit alsoStart);
    @(negedge clk); failStrobe = 1'b1; failCode = code; failRam = ram; selfTestStart = alsoStart;
    @(negedge clk); failStrobe = 1'b0; selfTestStart = 1'b0;
  endtask

  // Walks the pin from the first cycle after failure entry; c = 0 is that cycle
  task automatic runWave(input int n, input bit ram, input int len, input int injAt,
                         input string req);
    int rises = 0, darkRun = 0, maxDark = 0, badAt = -1, p, gotV = 0, expV = 0;
    bit seenOn = 1'b0, prevOn = 1'b0;
    p = ram ? 2 : 2 * n - 1 + GAP;
    for (int c = 0; c < len; c++) begin
      bit e, on;
      e = expOn(n, ram, c);
      if (badAt < 0 && (ledPinN !== ~e || modeDbg !== (ram ? 2'd3 : 2'd2))) begin
        badAt = c; gotV = {modeDbg, ledPinN}; expV = {(ram ? 2'd3 : 2'd2), ~e};
      end
      on = (ledPinN === 1'b0);
      if (on && !prevOn && c >= DIV && c < DIV + p * DIV) rises++;
      if (on) begin
        if (seenOn && darkRun > maxDark) maxDark = darkRun;
        darkRun = 0; seenOn = 1'b1;
      end else if (seenOn) darkRun++;
      prevOn = on;
      selfTestStart = (c == injAt);
      failStrobe    = (c == injAt);
      failCode      = 4'd5;
      failRam       = ~ram;
      @(negedge clk);
    end
    selfTestStart = 1'b0; failStrobe = 1'b0;
    check(badAt < 0, req, $sformatf("waveform {mode,pin} at cycle %0d", badAt), gotV, expV);
    if (!ram && injAt < 0) begin
      check(rises == n, "R4", "flashes in one burst", rises, n);
      check(maxDark == GAP * DIV, "R5", "inter-burst dark cycles", maxDark, GAP * DIV);
    end
    if (ram && injAt < 0)
      check(maxDark == DIV, "R6", "longest dark run", maxDark, DIV);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 / R11: reset state
    check(ledPinN === 1'b1, "R2", "pin after reset", ledPinN, 1);
    check(modeDbg === 2'd0, "R11", "mode after reset", modeDbg, 0);

    // R2: stays dark with no strobes
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        if (ledPinN !== 1'b1 || modeDbg !== 2'd0) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R2", "cycles not dark while idle", bad, 0);
    end

    // Vector table: R4 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      int n, p;
      doReset();
      if (VEC[v].pre) begin
        pulseStart();
        check(ledPinN === 1'b0 && modeDbg === 2'd1, "R3",
              $sformatf("solid after start, vector %0d", v), {modeDbg, ledPinN}, 3'b010);
      end
      n = VEC[v].expN;
      p = VEC[v].ram ? 2 : 2 * n - 1 + GAP;
      pulseFail(VEC[v].code, VEC[v].ram, 1'b0);
      runWave(n, VEC[v].ram, DIV + 2 * p * DIV + 2, -10,
              VEC[v].code > 8 || VEC[v].code < 2 ? "R7" : (VEC[v].ram ? "R6" : "R8"));
    end

    // R3 / R1: solid held with no further input
    doReset();
    pulseStart();
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        if (ledPinN !== 1'b0 || modeDbg !== 2'd1) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R1", "cycles solid not lit", bad, 0);
    end
    // R3: repeated start keeps solid
    pulseStart();
    check(modeDbg === 2'd1 && ledPinN === 1'b0, "R3", "second start", {modeDbg, ledPinN}, 3'b010);

    // R9: strobes ignored while coded blinking
    pulseFail(4'd3, 1'b0, 1'b0);
    runWave(3, 1'b0, 60, 10, "R9");
    // R9: strobes ignored while memory-fail blinking
    doReset();
    pulseFail(4'd6, 1'b1, 1'b0);
    runWave(0, 1'b1, 40, 7, "R9");

    // R2: reset leaves a blink mode
    doReset();
    check(modeDbg === 2'd0 && ledPinN === 1'b1, "R2", "reset from blink", {modeDbg, ledPinN}, 3'b001);

    // R10: simultaneous start and failure -> failure wins
    pulseFail(4'd2, 1'b0, 1'b1);
    runWave(2, 1'b0, 40, -10, "R10");

    // R12: pin constant within each tick, tested on memory-fail pattern
    doReset();
    pulseFail(4'd2, 1'b1, 1'b0);
    begin
      int bad = 0;
      logic prev;
      prev = ledPinN;
      for (int c = 1; c < 30; c++) begin
        @(negedge clk);
        if (ledPinN !== prev && (c % DIV) != 0) bad++;
        prev = ledPinN;
      end
      check(bad == 0, "R12", "changes off tick boundary", bad, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule